// File: doc/BRIEF.md
# CAN Interrupt Grouping and Configuration Lock

This block is the register side of a CAN controller. It keeps one sticky flag per core event (one wakeup, six error conditions, one receive-full, and one empty flag per transmit buffer), one enable per flag, and folds the enabled flags into four level interrupt requests: wakeup, error, receive and transmit. A global interrupt-disable input from the CPU suppresses all four requests.

The same register file holds the controller configuration: operating mode, two bit-timing bytes, acceptance control, four acceptance-code bytes and four acceptance-mask bytes. These bytes change only while the soft-reset bit is set. Outside soft reset the controller is treated as on-line, and writes to them are dropped. The receive and transmit error counters, which the core maintains, appear as read-only registers. The transmit output is driven recessive whenever a low-power mode is active.

Software uses a plain single-cycle write strobe and a combinational read port. The core supplies one-cycle event pulses, the error counter values and its transmit bit.

Top module: `can_irq_lock_top`

## Requirements
- R1: `irq_wake_o` is high exactly while the wakeup flag (flag register 0x10 bit 0) and its enable (0x12 bit 0) are both set and `cpu_imask_i` is low.
- R2: `irq_err_o` is the OR of six enabled flags at 0x10 bits 1..6 (receive warning, transmit warning, receive passive, transmit passive, bus-off, overrun), each gated by the matching enable bit at 0x12, and is low while `cpu_imask_i` is high.
- R3: `irq_tx_o` is the OR of the buffer-empty flags at 0x11 bits 0..2, each gated by its enable at 0x13 bits 0..2, and is low while `cpu_imask_i` is high.
- R4: `irq_rx_o` follows the receive-full flag (0x10 bit 7) gated by its enable (0x12 bit 7) and by a low `cpu_imask_i`.
- R5: While `cpu_imask_i` is high, all four request outputs are low whatever the flags and enables hold.
- R6: Event pulse `evt_i[k]` sets flag k on the next clock edge. Flag k sits at register 0x10+k/8, bit k%8. Writing 1 to a flag bit clears it; writing 0 leaves it unchanged.
- R7: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: The configuration bytes sit at 0x01 (mode), 0x02..0x03 (timing), 0x04 (acceptance control), 0x05..0x08 (codes) and 0x09..0x0C (masks). A write to them takes effect only while the soft-reset bit is 1. Otherwise it is ignored.
- R9: The soft-reset bit is bit 0 of register 0x00. It is 1 after reset and can be written at any time.
- R10: Registers 0x14 and 0x15 return `rx_err_cnt_i` and `tx_err_cnt_i`. Bus writes to them change nothing.
- R11: Reading a configuration byte returns its stored value whether the lock is open or closed.
- R12: `tx_o` is 1 while `low_power_i` is high and otherwise equals `tx_core_i`.
- R13: After reset all flags and enables are 0 and all four requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| evt_i | input | 11 | One-cycle event pulses, bit k sets flag k |
| cpu_imask_i | input | 1 | Global interrupt disable |
| rx_err_cnt_i | input | 8 | Receive error counter from the core |
| tx_err_cnt_i | input | 8 | Transmit error counter from the core |
| low_power_i | input | 1 | Any low-power mode active |
| tx_core_i | input | 1 | Transmit bit from the core |
| tx_o | output | 1 | Transmit pin |
| irq_wake_o | output | 1 | Wakeup request |
| irq_err_o | output | 1 | Error request |
| irq_rx_o | output | 1 | Receive request |
| irq_tx_o | output | 1 | Transmit request |
| srst_o | output | 1 | Soft-reset bit |
| cfg_mode_o | output | 8 | Mode byte |
| cfg_tim_o | output | 16 | Timing bytes, 0x03 in the high byte |
| cfg_acc_o | output | 8 | Acceptance control byte |
| cfg_code_o | output | 32 | Acceptance codes, 0x05 in the low byte |
| cfg_mask_o | output | 32 | Acceptance masks, 0x09 in the low byte |

## Verification
The grouping is swept over every flag index, with its enable on and off and the global mask on and off. That sweep shows whether each source reaches the right request line and no other, and whether the enable and the mask both gate it. Each configuration byte is written once with the lock open and again with it closed, using a complementary value. The readback then separates an ignored write from a corrupted or missing register. Further patterns cover two error flags with only one of them cleared, a write of zeros to the flag registers, an event pulse arriving in the same cycle as its clear, writes to the counter registers under changing counter inputs, and all four combinations of the low-power input and the core transmit bit.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 8;
  localparam int unsigned NCFG = 12;

  localparam logic [AW-1:0] A_CTRL  = 5'h00;
  localparam logic [AW-1:0] A_MODE  = 5'h01;
  localparam logic [AW-1:0] A_FLAG0 = 5'h10;
  localparam logic [AW-1:0] A_EN0   = 5'h12;
  localparam logic [AW-1:0] A_RXCNT = 5'h14;
  localparam logic [AW-1:0] A_TXCNT = 5'h15;

  // flag index layout; grouping depends on it
  localparam int unsigned F_WAKE   = 0;
  localparam int unsigned F_ERR_LO = 1;
  localparam int unsigned F_ERR_HI = 6;
  localparam int unsigned F_RX     = 7;
  localparam int unsigned F_TX_LO  = 8;
endpackage

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_ctl_pkg::*;
#(
  parameter int unsigned NFLAG = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NFLAG-1:0] flag_o,
  output logic [NFLAG-1:0] en_o
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int unsigned BYTE = i / DW;
    localparam int unsigned BIT  = i % DW;
    localparam logic [AW-1:0] FA = A_FLAG0 + AW'(BYTE);
    localparam logic [AW-1:0] EA = A_EN0 + AW'(BYTE);

    logic clr_w, en_wr;
    assign clr_w = we_i && (addr_i == FA) && wdata_i[BIT];
    assign en_wr = we_i && (addr_i == EA);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (evt_i[i]) flag_o[i] <= 1'b1;  // set beats clear
      else if (clr_w)    flag_o[i] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_o[i] <= 1'b0;
      else if (en_wr) en_o[i] <= wdata_i[BIT];
    end
  end
endmodule

// File: rtl/can_cfg_lock.sv
module can_cfg_lock
  import can_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               srst_o,
  output logic [NCFG*DW-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        srst_o <= 1'b1;
    else if (we_i && addr_i == A_CTRL) srst_o <= wdata_i[0];
  end

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    localparam logic [AW-1:0] CA = A_MODE + AW'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_o[k*DW +: DW] <= '0;
      else if (we_i && addr_i == CA && srst_o)  cfg_o[k*DW +: DW] <= wdata_i;
    end
  end
endmodule

// File: rtl/can_irq_group.sv
module can_irq_group
  import can_ctl_pkg::*;
#(
  parameter int unsigned NFLAG = 11
) (
  input  logic [NFLAG-1:0] flag_i,
  input  logic [NFLAG-1:0] en_i,
  input  logic             imask_i,
  output logic             wake_o,
  output logic             err_o,
  output logic             rx_o,
  output logic             tx_o
);
  logic [NFLAG-1:0] act;
  assign act = flag_i & en_i;

  assign wake_o = act[F_WAKE] & ~imask_i;
  assign err_o  = (|act[F_ERR_HI:F_ERR_LO]) & ~imask_i;
  assign rx_o   = act[F_RX] & ~imask_i;
  assign tx_o   = (|act[NFLAG-1:F_TX_LO]) & ~imask_i;
endmodule

// File: rtl/can_irq_lock_top.sv
module can_irq_lock_top
  import can_ctl_pkg::*;
#(
  parameter int unsigned NUM_TXB = 3,
  localparam int unsigned NFLAG = F_TX_LO + NUM_TXB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             cpu_imask_i,
  input  logic [DW-1:0]    rx_err_cnt_i,
  input  logic [DW-1:0]    tx_err_cnt_i,
  input  logic             low_power_i,
  input  logic             tx_core_i,
  output logic             tx_o,
  output logic             irq_wake_o,
  output logic             irq_err_o,
  output logic             irq_rx_o,
  output logic             irq_tx_o,
  output logic             srst_o,
  output logic [DW-1:0]    cfg_mode_o,
  output logic [2*DW-1:0]  cfg_tim_o,
  output logic [DW-1:0]    cfg_acc_o,
  output logic [4*DW-1:0]  cfg_code_o,
  output logic [4*DW-1:0]  cfg_mask_o
);
  logic [NFLAG-1:0]   flag_q, en_q;
  logic [NCFG*DW-1:0] cfg_q;
  logic [2*DW-1:0]    flag_pad, en_pad;

  can_irq_flags #(.NFLAG(NFLAG)) u_flags (
    .clk_i, .rst_ni, .evt_i, .we_i, .addr_i, .wdata_i,
    .flag_o(flag_q), .en_o(en_q)
  );

  can_cfg_lock u_cfg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .srst_o, .cfg_o(cfg_q)
  );

  can_irq_group #(.NFLAG(NFLAG)) u_grp (
    .flag_i(flag_q), .en_i(en_q), .imask_i(cpu_imask_i),
    .wake_o(irq_wake_o), .err_o(irq_err_o), .rx_o(irq_rx_o), .tx_o(irq_tx_o)
  );

  assign cfg_mode_o = cfg_q[0*DW +: DW];
  assign cfg_tim_o  = cfg_q[1*DW +: 2*DW];
  assign cfg_acc_o  = cfg_q[3*DW +: DW];
  assign cfg_code_o = cfg_q[4*DW +: 4*DW];
  assign cfg_mask_o = cfg_q[8*DW +: 4*DW];

  assign tx_o = low_power_i | tx_core_i;  // recessive is 1

  assign flag_pad = (2*DW)'(flag_q);
  assign en_pad   = (2*DW)'(en_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)
      rdata_o = DW'(srst_o);
    else if (addr_i >= A_MODE && addr_i < A_MODE + AW'(NCFG))
      rdata_o = cfg_q[(addr_i - A_MODE)*DW +: DW];
    else if (addr_i == A_FLAG0)      rdata_o = flag_pad[DW-1:0];
    else if (addr_i == A_FLAG0 + 1)  rdata_o = flag_pad[2*DW-1:DW];
    else if (addr_i == A_EN0)        rdata_o = en_pad[DW-1:0];
    else if (addr_i == A_EN0 + 1)    rdata_o = en_pad[2*DW-1:DW];
    else if (addr_i == A_RXCNT)      rdata_o = rx_err_cnt_i;
    else if (addr_i == A_TXCNT)      rdata_o = tx_err_cnt_i;
  end
endmodule

// File: rtl/can_irq_lock_chk.sv
module can_irq_lock_chk
  import can_ctl_pkg::*;
#(
  parameter int unsigned NFLAG = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    rdata_o,
  input logic [NFLAG-1:0] evt_i,
  input logic [NFLAG-1:0] flag_q,
  input logic             cpu_imask_i,
  input logic [DW-1:0]    rx_err_cnt_i,
  input logic [DW-1:0]    tx_err_cnt_i,
  input logic             low_power_i,
  input logic             tx_o,
  input logic             irq_wake_o,
  input logic             irq_err_o,
  input logic             irq_rx_o,
  input logic             irq_tx_o,
  input logic             srst_o,
  input logic [DW-1:0]    cfg_mode_o
);
  assert_wake_needs_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wake_o |-> flag_q[F_WAKE]);

  assert_mask_silences_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_imask_i |-> !(irq_wake_o || irq_err_o || irq_rx_o || irq_tx_o));

  assert_event_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  assert_mode_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MODE && !srst_o) |=> $stable(cfg_mode_o));

  assert_rx_cnt_visible_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_RXCNT) |-> (rdata_o == rx_err_cnt_i));

  assert_tx_cnt_visible_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_TXCNT) |-> (rdata_o == tx_err_cnt_i));

  assert_recessive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_i |-> tx_o);
endmodule

bind can_irq_lock_top can_irq_lock_chk #(.NFLAG(NFLAG)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .rdata_o, .evt_i, .flag_q,
  .cpu_imask_i, .rx_err_cnt_i, .tx_err_cnt_i, .low_power_i, .tx_o,
  .irq_wake_o, .irq_err_o, .irq_rx_o, .irq_tx_o, .srst_o, .cfg_mode_o
);

// File: tb/can_irq_lock_top_test.sv
module can_irq_lock_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [10:0] evt = '0;
  logic        imask = 1'b0;
  logic [7:0]  rxc = '0, txc = '0;
  logic        lp = 1'b0, txc_bit = 1'b0;
  logic        tx, i_wk, i_er, i_rx, i_tx, srst;
  logic [7:0]  c_mode, c_acc;
  logic [15:0] c_tim;
  logic [31:0] c_code, c_mask;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  can_irq_lock_top uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .cpu_imask_i(imask),
    .rx_err_cnt_i(rxc), .tx_err_cnt_i(txc), .low_power_i(lp),
    .tx_core_i(txc_bit), .tx_o(tx), .irq_wake_o(i_wk), .irq_err_o(i_er),
    .irq_rx_o(i_rx), .irq_tx_o(i_tx), .srst_o(srst), .cfg_mode_o(c_mode),
    .cfg_tim_o(c_tim), .cfg_acc_o(c_acc), .cfg_code_o(c_code), .cfg_mask_o(c_mask)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(int k);
    @(negedge clk);
    evt[k] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  function automatic logic [3:0] grp(int k);  // {tx,rx,err,wake}
    if (k == 0) return 4'b0001;
    if (k <= 6) return 4'b0010;
    if (k == 7) return 4'b0100;
    return 4'b1000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state, R9 soft reset set
    @(negedge clk); #1;
    check("R13 irqs", {i_tx, i_rx, i_er, i_wk}, 4'h0);
    rd(5'h10, r); check("R13 flags0", r, 8'h00);
    rd(5'h11, r); check("R13 flags1", r, 8'h00);
    rd(5'h12, r); check("R13 en0", r, 8'h00);
    rd(5'h13, r); check("R13 en1", r, 8'h00);
    rd(5'h00, r); check("R9 srst after reset", r, 8'h01);

    // R1..R6 sweep: every flag, enable on/off, mask on/off
    for (int k = 0; k < 11; k++) begin
      for (int e = 0; e < 2; e++) begin
        for (int m = 0; m < 2; m++) begin
          logic [15:0] en16;
          logic [3:0] exp;
          en16 = (e != 0) ? (16'h1 << k) : 16'h0;
          wr(5'h12, en16[7:0]);
          wr(5'h13, en16[15:8]);
          imask = (m != 0);
          pulse(k);
          #1;
          exp = (e != 0 && m == 0) ? grp(k) : 4'h0;
          check("R1 R2 R3 R4 R5 grouping", {i_tx, i_rx, i_er, i_wk}, exp);
          rd(5'h10 + 5'(k / 8), r);
          check("R6 flag set", r, 8'h1 << (k % 8));
          wr(5'h10 + 5'(k / 8), 8'h00);
          rd(5'h10 + 5'(k / 8), r);
          check("R6 write 0 keeps", r, 8'h1 << (k % 8));
          wr(5'h10 + 5'(k / 8), 8'h1 << (k % 8));
          #1;
          check("R6 clear drops irq", {i_tx, i_rx, i_er, i_wk}, 4'h0);
          rd(5'h10 + 5'(k / 8), r);
          check("R6 flag cleared", r, 8'h00);
        end
      end
    end
    imask = 1'b0;

    // R2 two error sources, clear one
    wr(5'h12, 8'h7E);
    pulse(2); pulse(5);
    wr(5'h10, 8'h04);
    #1 check("R2 other error keeps irq", i_er, 1'b1);
    wr(5'h10, 8'h20);
    #1 check("R2 all cleared", i_er, 1'b0);

    // R3 two buffers, clear one
    wr(5'h13, 8'h07);
    pulse(8); pulse(10);
    wr(5'h11, 8'h01);
    #1 check("R3 other buffer keeps irq", i_tx, 1'b1);
    wr(5'h11, 8'h04);
    #1 check("R3 all cleared", i_tx, 1'b0);

    // R7 set and clear in same cycle
    @(negedge clk);
    evt[3] = 1'b1; we = 1'b1; addr = 5'h10; wdata = 8'h08;
    @(negedge clk);
    evt = '0; we = 1'b0;
    rd(5'h10, r); check("R7 set wins", r, 8'h08);
    wr(5'h10, 8'hFF);

    // R8 R11 open lock writes
    for (int a = 1; a <= 12; a++) begin
      wr(5'(a), 8'(8'h30 + a * 8'h11));
      rd(5'(a), r); check("R8 open write", r, 8'(8'h30 + a * 8'h11));
    end
    check("R8 mode port", c_mode, 8'h41);
    check("R8 acc port", c_acc, 8'h74);
    // R9 close lock
    wr(5'h00, 8'h00);
    rd(5'h00, r); check("R9 srst cleared", r, 8'h00);
    for (int a = 1; a <= 12; a++) begin
      wr(5'(a), ~8'(8'h30 + a * 8'h11));
      rd(5'(a), r); check("R8 R11 locked write ignored", r, 8'(8'h30 + a * 8'h11));
    end
    check("R8 timing port", c_tim, 16'h6352);
    check("R8 code port", c_code, 32'hB8A79685);
    check("R8 mask port", c_mask, 32'hFCEBDAC9);
    wr(5'h00, 8'h01);
    wr(5'h01, 8'h5C);
    rd(5'h01, r); check("R9 R8 reopened", r, 8'h5C);

    // R10 counters read-only
    rxc = 8'h5A; txc = 8'hA5;
    wr(5'h14, 8'h00); wr(5'h15, 8'hFF);
    rd(5'h14, r); check("R10 rx count", r, 8'h5A);
    rd(5'h15, r); check("R10 tx count", r, 8'hA5);
    rxc = 8'h81; txc = 8'h7F;
    rd(5'h14, r); check("R10 rx follows", r, 8'h81);
    rd(5'h15, r); check("R10 tx follows", r, 8'h7F);

    // R12 transmit pin
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      lp = p[1]; txc_bit = p[0];
      #1 check("R12 tx pin", tx, (p[1] | p[0]));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule